// File: doc/BRIEF.md
# Reset Supervisor with Fault-Cause Register

This block drives the system reset of a chip. It watches a power-good signal, three low-voltage comparator flags, a manual-reset request and a watchdog kick line. While any of these causes is active, it holds the reset output high. When the causes go away, it keeps the reset asserted for a delay chosen from a small table. A watchdog also asserts reset when software stops toggling the kick line within the selected period. A tick input that pulses once per millisecond sets all timing, so the counters count ticks and not clock cycles.

Each reset cause leaves a sticky bit in a byte-wide status register. The register has no unlock sequence. Software reads it at address 0xFF and can clear or set its cause bits with a single-byte write to the same address. A power-on reset clears it.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1 and the fault register reads 0x00.
- R2: If `pwr_good` is low, or any `lv_flag` bit is high, or `man_rst` is high at a clock edge, then `sys_rst` is 1 after that edge.
- R3: Reset is released after N tick edges with every cause inactive, counted from the first edge at which all causes are inactive. N depends on `pup_sel`: 0 gives 50, 1 gives 200, 2 gives 400, 3 gives 800. Edges without a tick are not counted.
- R4: With `sys_rst` low and the watchdog enabled, `sys_rst` rises on the M-th tick edge after release if there is no kick edge in that time. M depends on `wd_sel`: 0 gives 1400, 1 gives 200, 2 gives 25. The same edge sets bit 4 (watchdog flag) of the fault register.
- R5: `wd_sel` = 3 disables the watchdog, so no timeout occurs however long the kick line stays idle.
- R6: A rising edge on `wd_kick` restarts the watchdog count. Holding `wd_kick` high does not restart it again.
- R7: Fault register layout: bit 7 records `lv_flag[0]`, bit 6 records `lv_flag[1]`, bit 5 records `lv_flag[2]`, bit 4 records a watchdog timeout and bit 3 records `man_rst`. Bits 2..0 always read 0. Each cause bit is set on the edge at which its cause is sampled, and it stays set.
- R8: A low-voltage flag does not set its fault bit while `pwr_good` is low.
- R9: A transfer opened by `bus_start` with `bus_addr` = 0xFF stores `bus_wdata` bits 7..3 from its first data byte into the register, and `bus_wack` is 1 during that byte. Written bits 2..0 are dropped.
- R10: Any data byte after the first in the same transfer gets `bus_wack` = 0 and changes nothing.
- R11: A transfer to any other address gets `bus_wack` = 0 and changes nothing. `rd_data` is 0x00 for any `rd_addr` other than 0xFF.
- R12: If a cause and an accepted write hit the same fault bit in the same cycle, the cause wins and the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_ms | input | 1 | One-cycle timing tick, once per millisecond |
| pwr_good | input | 1 | Supply is within range |
| lv_flag | input | 3 | Low-voltage comparator flags |
| man_rst | input | 1 | Manual reset request, active high |
| wd_kick | input | 1 | Watchdog service line; a rising edge restarts the watchdog |
| pup_sel | input | 2 | Release delay code |
| wd_sel | input | 2 | Watchdog period code; 3 disables the watchdog |
| bus_start | input | 1 | Opens a write transfer |
| bus_addr | input | 8 | Target address of the transfer |
| bus_wvld | input | 1 | Data byte valid |
| bus_wdata | input | 8 | Data byte |
| bus_wack | output | 1 | Data byte accepted |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data |
| sys_rst | output | 1 | System reset, active high |

## Verification
The assertions assume that all cause inputs, the kick line and the bus signals are synchronous to `clk`. They also assume that `bus_start` and `bus_wvld` are never high in the same cycle, so a data byte always belongs to a transfer that is already open. The stimulus meets these assumptions:
- Every input changes on the falling clock edge.
- A transfer is opened one cycle before its first data byte.
- The tick is held high, so the tick count equals the cycle count, except during one interval where it is held low on purpose to show that counting pauses.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int N_LV    = 3;
  localparam int FLT_LV1 = 7;
  localparam int FLT_WD  = 4;
  localparam int FLT_MR  = 3;
  localparam logic [7:0] FLT_ADDR  = 8'hFF;
  localparam logic [7:0] FLT_WMASK = 8'hF8;
  localparam logic [1:0] WD_OFF    = 2'b11;

  // Selects one of four table entries by a two-bit code
  function automatic int unsigned pick4(input logic [1:0] code,
                                        input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
    case (code)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return c;
      default: return d;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Next fault value: the write loads first, then set events are ORed in (set wins)
  function automatic logic [7:0] fault_next(input logic [7:0] cur, input logic [7:0] set,
                                            input logic wr, input logic [7:0] wdata);
    logic [7:0] base;
    base = wr ? (wdata & FLT_WMASK) : cur;
    return (base | set) & FLT_WMASK;
  endfunction
endpackage

// File: rtl/rsv_release_timer.sv
module rsv_release_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             rst_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nx;
  logic             reached;

  assign cnt_nx  = {1'b0, cnt} + (CNT_W+1)'(1);
  assign reached = cnt_nx >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rst_o <= 1'b1;
    end else if (hold) begin
      cnt   <= '0;
      rst_o <= 1'b1;
    end else if (rst_o && tick) begin
      if (reached) begin
        rst_o <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt_nx[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic             sys_rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  output logic             kick_edge,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nx;
  logic             kick_q;

  assign cnt_nx    = {1'b0, cnt} + (CNT_W+1)'(1);
  assign kick_edge = kick & ~kick_q;
  assign expire    = enable & ~sys_rst & tick & ~kick_edge & (cnt_nx >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= kick;
      if (sys_rst || !enable || kick_edge || expire) cnt <= '0;
      else if (tick)                                  cnt <= cnt_nx[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rsv_fault_reg.sv
module rsv_fault_reg
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_bits,
  input  logic       bus_start,
  input  logic [7:0] bus_addr,
  input  logic       bus_wvld,
  input  logic [7:0] bus_wdata,
  input  logic [7:0] rd_addr,
  output logic [7:0] fault_q,
  output logic [7:0] rd_data,
  output logic       wr_accept
);
  logic xfer_hit;
  logic xfer_used;

  assign wr_accept = bus_wvld & xfer_hit & ~xfer_used;
  assign rd_data   = (rd_addr == FLT_ADDR) ? fault_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_hit  <= 1'b0;
      xfer_used <= 1'b0;
    end else if (bus_start) begin
      xfer_hit  <= (bus_addr == FLT_ADDR);
      xfer_used <= 1'b0;
    end else if (bus_wvld) begin
      xfer_used <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 8'h00;
    else        fault_q <= fault_next(fault_q, set_bits, wr_accept, bus_wdata);
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int unsigned PUP_T0 = 50,
  parameter int unsigned PUP_T1 = 200,
  parameter int unsigned PUP_T2 = 400,
  parameter int unsigned PUP_T3 = 800,
  parameter int unsigned WD_T0  = 1400,
  parameter int unsigned WD_T1  = 200,
  parameter int unsigned WD_T2  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       pwr_good,
  input  logic [2:0] lv_flag,
  input  logic       man_rst,
  input  logic       wd_kick,
  input  logic [1:0] pup_sel,
  input  logic [1:0] wd_sel,
  input  logic       bus_start,
  input  logic [7:0] bus_addr,
  input  logic       bus_wvld,
  input  logic [7:0] bus_wdata,
  output logic       bus_wack,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sys_rst
);
  localparam int unsigned T_MAX = max2(max2(max2(PUP_T0, PUP_T1), max2(PUP_T2, PUP_T3)),
                                       max2(max2(WD_T0, WD_T1), WD_T2));
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic             cause_now;
  logic             wd_expire;
  logic             kick_edge;
  logic             wd_en;
  logic             wr_accept;
  logic [CNT_W-1:0] pup_lim;
  logic [CNT_W-1:0] wd_lim;
  logic [7:0]       set_bits;
  logic [7:0]       fault_q;

  assign cause_now = ~pwr_good | (|lv_flag) | man_rst;
  assign pup_lim   = CNT_W'(pick4(pup_sel, PUP_T0, PUP_T1, PUP_T2, PUP_T3));
  assign wd_lim    = CNT_W'(pick4(wd_sel, WD_T0, WD_T1, WD_T2, 0));
  assign wd_en     = (wd_sel != WD_OFF);
  assign bus_wack  = wr_accept;

  for (genvar i = 0; i < N_LV; i++) begin : g_lv
    assign set_bits[FLT_LV1-i] = pwr_good & lv_flag[i];
  end
  assign set_bits[FLT_WD] = wd_expire;
  assign set_bits[FLT_MR] = man_rst;
  assign set_bits[2:0]    = 3'b000;

  rsv_release_timer #(.CNT_W(CNT_W)) u_rel (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .hold  (cause_now | wd_expire),
    .limit (pup_lim),
    .rst_o (sys_rst)
  );

  rsv_watchdog #(.CNT_W(CNT_W)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .kick      (wd_kick),
    .sys_rst   (sys_rst),
    .enable    (wd_en),
    .limit     (wd_lim),
    .kick_edge (kick_edge),
    .expire    (wd_expire)
  );

  rsv_fault_reg u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_bits  (set_bits),
    .bus_start (bus_start),
    .bus_addr  (bus_addr),
    .bus_wvld  (bus_wvld),
    .bus_wdata (bus_wdata),
    .rd_addr   (rd_addr),
    .fault_q   (fault_q),
    .rd_data   (rd_data),
    .wr_accept (wr_accept)
  );
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk
  import rsv_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       cause_now,
  input logic       wd_expire,
  input logic       pwr_good,
  input logic       man_rst,
  input logic       bus_start,
  input logic       wr_accept,
  input logic [1:0] wd_sel,
  input logic [7:0] fault_q
);
  // R2
  cause_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_now |=> sys_rst);

  // R3
  release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> $past(!cause_now));

  // R4
  wd_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (sys_rst && fault_q[FLT_WD]));

  // R5
  wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_sel == WD_OFF) |-> !wd_expire);

  // R7
  mr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst |=> fault_q[FLT_MR]);

  // R8
  lv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !wr_accept) |=> $stable(fault_q[7:5]));

  // R10
  one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !bus_start) |=> !wr_accept);
endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_rst   (sys_rst),
  .cause_now (cause_now),
  .wd_expire (wd_expire),
  .pwr_good  (pwr_good),
  .man_rst   (man_rst),
  .bus_start (bus_start),
  .wr_accept (wr_accept),
  .wd_sel    (wd_sel),
  .fault_q   (fault_q)
);

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, tick_ms, pwr_good, man_rst, wd_kick;
  logic [2:0] lv_flag;
  logic [1:0] pup_sel, wd_sel;
  logic       bus_start, bus_wvld;
  logic [7:0] bus_addr, bus_wdata, rd_addr;
  logic       bus_wack, sys_rst;
  logic [7:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_supervisor u_rst_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_good(pwr_good),
    .lv_flag(lv_flag), .man_rst(man_rst), .wd_kick(wd_kick),
    .pup_sel(pup_sel), .wd_sel(wd_sel), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_wvld(bus_wvld), .bus_wdata(bus_wdata),
    .bus_wack(bus_wack), .rd_addr(rd_addr), .rd_data(rd_data), .sys_rst(sys_rst)
  );

  function automatic int pup_ticks(input int p);
    return (p == 0) ? 50 : 100 * (1 << p);
  endfunction

  function automatic int wd_ticks(input int w);
    return (w == 0) ? 7 * 200 : 200 >> (3 * (w - 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_release();
    bit done = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sys_rst == 1'b0) begin done = 1'b1; break; end
    end
    chk("R3 release", done, 1'b1);
  endtask

  task automatic wr_xfer(input logic [7:0] addr, input logic [7:0] d0, input logic exp_ack,
                         input bit two, input logic [7:0] d1, input string req);
    @(negedge clk); bus_start = 1'b1; bus_addr = addr;
    @(negedge clk); bus_start = 1'b0; bus_wvld = 1'b1; bus_wdata = d0;
    #1 chk(req, bus_wack, exp_ack);
    if (two) begin
      @(negedge clk); bus_wdata = d1;
      #1 chk("R10 second byte", bus_wack, 1'b0);
    end
    @(negedge clk); bus_wvld = 1'b0;
  endtask

  // Pulses pwr_good low and returns at the negedge where it is high again
  task automatic pg_pulse();
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk); pwr_good = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_ms = 1'b1; pwr_good = 1'b0; lv_flag = 3'b000; man_rst = 1'b0;
    wd_kick = 1'b0; pup_sel = 2'd1; wd_sel = 2'd3; bus_start = 1'b0; bus_wvld = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; rd_addr = 8'hFF;
    edges(3);
    // R1 reset state
    chk("R1 sys_rst", sys_rst, 1'b1);
    chk("R1 fault", rd_data, 8'h00);
    rst_n = 1'b1;

    // R8: low-voltage flags ignored for the register while power is bad
    lv_flag = 3'b111;
    edges(4);
    chk("R8 fault", rd_data, 8'h00);
    chk("R2 power bad", sys_rst, 1'b1);
    lv_flag = 3'b000;
    pwr_good = 1'b1;
    wait_release();

    // R3: release delay sweep over all codes
    for (int p = 0; p < 4; p++) begin
      pup_sel = 2'(p);
      pg_pulse();
      chk("R2 power pulse", sys_rst, 1'b1);
      edges(pup_ticks(p) - 1);
      chk("R3 before delay", sys_rst, 1'b1);
      edges(1);
      chk("R3 at delay", sys_rst, 1'b0);
    end

    // R3: edges without tick are not counted
    pup_sel = 2'd0;
    pg_pulse();
    tick_ms = 1'b0;
    edges(1000);
    chk("R3 no tick", sys_rst, 1'b1);
    tick_ms = 1'b1;
    edges(49);
    chk("R3 tick resumes before", sys_rst, 1'b1);
    edges(1);
    chk("R3 tick resumes at", sys_rst, 1'b0);

    // R7: each low-voltage flag sets its own bit
    for (int i = 0; i < 3; i++) begin
      lv_flag = 3'(1 << i);
      edges(1);
      chk("R2 lv", sys_rst, 1'b1);
      chk("R7 lv bit", rd_data, 8'h80 >> i);
      lv_flag = 3'b000;
      wr_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, "R9 clear ack");
      chk("R9 cleared", rd_data, 8'h00);
      wait_release();
    end

    // R7 manual reset
    man_rst = 1'b1;
    edges(1);
    man_rst = 1'b0;
    chk("R2 mr", sys_rst, 1'b1);
    chk("R7 mr bit", rd_data, 8'h08);
    wait_release();

    // R9 write, low bits dropped; R10 second byte rejected; R11 other address
    wr_xfer(8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00, "R9 ack");
    chk("R9 write value", rd_data, 8'hF8);
    wr_xfer(8'h10, 8'h00, 1'b0, 1'b0, 8'h00, "R11 other addr ack");
    chk("R11 unchanged", rd_data, 8'hF8);
    rd_addr = 8'h00;
    #1 chk("R11 read other", rd_data, 8'h00);
    rd_addr = 8'hFF;
    wr_xfer(8'hFF, 8'h50, 1'b1, 1'b0, 8'h00, "R9 ack2");
    chk("R9 partial", rd_data, 8'h50);

    // R12: set beats a write of zero to the same bit
    @(negedge clk); bus_start = 1'b1; bus_addr = 8'hFF;
    @(negedge clk); bus_start = 1'b0; bus_wvld = 1'b1; bus_wdata = 8'h00; man_rst = 1'b1;
    @(negedge clk); bus_wvld = 1'b0; man_rst = 1'b0;
    chk("R12 set wins", rd_data, 8'h08);
    wr_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, "R9 clear ack");
    wait_release();

    // R4: watchdog period sweep
    pup_sel = 2'd0;
    for (int w = 0; w < 3; w++) begin
      wd_sel = 2'(w);
      pg_pulse();
      edges(50);
      chk("R3 release before wd", sys_rst, 1'b0);
      edges(wd_ticks(w) - 1);
      chk("R4 before timeout", sys_rst, 1'b0);
      edges(1);
      chk("R4 timeout rst", sys_rst, 1'b1);
      chk("R4 timeout flag", rd_data, 8'h10);
      wd_sel = 2'd3;
      wr_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, "R9 clear ack");
      wait_release();
    end

    // R6: kick edge restarts, held level does not
    wd_sel = 2'd2;
    pg_pulse();
    edges(50);
    edges(20);
    chk("R6 before kick", sys_rst, 1'b0);
    wd_kick = 1'b1;
    edges(25);
    chk("R6 restarted", sys_rst, 1'b0);
    edges(1);
    chk("R6 timeout after kick", sys_rst, 1'b1);
    wd_kick = 1'b0;
    wd_sel = 2'd3;
    wr_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, "R9 clear ack");
    wait_release();

    // R5: disabled watchdog never fires
    edges(1600);
    chk("R5 no timeout", sys_rst, 1'b0);
    chk("R5 no flag", rd_data, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule